// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block checks the rate of a fast monitored clock against a free-running reference clock. A divider in the monitored domain marks every 32 monitored-clock cycles by flipping a toggle signal. That toggle is carried into the reference domain through a two-flop synchronizer. In the reference domain, a power-of-two prescaler turns reference cycles into ticks. An 8-bit window counter counts those ticks between successive toggle edges.

At each window end, the count is latched onto `meas_count` and checked against an inclusive pair of 8-bit bounds. Software reads `meas_count` while the clock runs normally and places its bounds one tick or more either side of that value. A count outside the bounds sets a sticky failure flag and produces one interrupt pulse.

A stopped monitored clock is caught by a timeout. The window counter saturates at 255. If a 256th tick arrives with no window edge, the window is closed with a count of zero. Any lower bound of 1 or more then reports the fault.

The control is a two-state machine:
- `ST_ARM` is entered at reset. A window edge in `ST_ARM` only restarts the counter and moves to `ST_RUN`, so the partial first window is dropped. A timeout in `ST_ARM` latches zero, compares it, and also moves to `ST_RUN`.
- In `ST_RUN`, a window edge latches and compares the count. A timeout latches and compares zero. Both restart the window and keep the state.

The prescale ratio is sampled only when a window restarts.

Top module: `clk_window_monitor`

## Requirements
- R1: After reset, `meas_count` is 0 and `fail_flag` and `fail_irq` are 0.
- R2: In `ST_RUN`, each window spans 32 monitored-clock cycles. `meas_count` holds the number of prescaled ticks in that window, with a ratio of 2 to the power `div_sel` (0→1, 1→2, 2→4, 3→8). With a 20 ns monitored clock and a 5 ns reference, this gives about 127, 63, 31 and 15.
- R3: A change of `div_sel` within a window does not affect that window's count. It applies from the next window onward.
- R4: A closed window whose count is below `bound_lo` sets `fail_flag`.
- R5: A closed window whose count is above `bound_hi` sets `fail_flag`.
- R6: A count with `bound_lo` ≤ count ≤ `bound_hi` leaves `fail_flag` at 0; both bounds are inclusive.
- R7: `fail_flag` stays set until `flag_clr` is high for one cycle. A violation in the same cycle as `flag_clr` keeps the flag set.
- R8: `fail_irq` is high for exactly one cycle, in the cycle that `fail_flag` first goes from 0 to 1. Further violations while the flag is set give no further pulse.
- R9: The window counter saturates at 255. If 256 ticks pass with no window edge, `meas_count` becomes 0 and is compared, so a stopped monitored clock with `bound_lo` = 1 sets `fail_flag`.
- R10: The first window edge after reset is not compared and does not latch. Only windows that begin at a window edge are checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | 1 | Monitored clock |
| div_sel | input | 2 | Prescale select, ratio 2^div_sel |
| bound_lo | input | 8 | Lowest accepted count |
| bound_hi | input | 8 | Highest accepted count |
| flag_clr | input | 1 | One-cycle clear of the failure flag |
| meas_count | output | 8 | Count latched at the last window end |
| fail_flag | output | 1 | Sticky out-of-bounds flag |
| fail_irq | output | 1 | One-cycle pulse when the flag sets |

## Verification
The bench uses the default parameters: an 8-bit count, a 32-cycle window, and a 2-bit select allowing ratios up to 8. It runs a 20 ns monitored clock against a 5 ns reference, so a full window takes 128 reference cycles. At these settings all four prescale ratios give counts well inside 8 bits. A stopped clock reaches the 256-tick timeout within a few hundred cycles, which keeps the timeout, first-window discard and mid-window select change within short directed runs.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
    typedef enum logic [0:0] {
        ST_ARM = 1'b0,
        ST_RUN = 1'b1
    } cfm_state_e;
endpackage

// File: rtl/cfm_mon_div.sv
// Monitored-domain divider: flips win_tog once every 2**WIN_LOG2 cycles.
module cfm_mon_div #(
    parameter int WIN_LOG2 = 5
) (
    input  logic mon_clk,
    input  logic rst_n,
    output logic win_tog
);
    logic [WIN_LOG2-1:0] div_q;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            win_tog <= 1'b0;
        end else begin
            div_q <= div_q + 1'b1;
            if (&div_q) begin
                win_tog <= ~win_tog;
            end
        end
    end
endmodule

// File: rtl/cfm_edge_sync.sv
// Synchronizes a toggle and reports each change as a one-cycle strobe.
module cfm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_o
);
    localparam int LEN = STAGES + 1;
    logic [LEN-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[LEN-2:0], async_in};
        end
    end

    assign edge_o = sh_q[LEN-1] ^ sh_q[LEN-2];
endmodule

// File: rtl/cfm_prescaler.sv
// Power-of-two tick generator; the ratio is loaded only on restart.
module cfm_prescaler #(
    parameter int SEL_W    = 2,
    parameter int MAX_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             restart,
    output logic             tick
);
    localparam int PRE_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_clamped;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        if (int'(sel_in) > MAX_LOG2) begin
            sel_clamped = SEL_W'(MAX_LOG2);
        end else begin
            sel_clamped = sel_in;
        end
    end

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(sel_q));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            pre_q <= '0;
        end else if (restart) begin
            sel_q <= sel_clamped;
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = ((pre_q & mask) == mask);
endmodule

// File: rtl/clk_window_monitor.sv
module clk_window_monitor #(
    parameter int CNT_W       = 8,
    parameter int WIN_LOG2    = 5,
    parameter int SEL_W       = 2,
    parameter int MAX_LOG2    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CNT_W-1:0] bound_lo,
    input  logic [CNT_W-1:0] bound_hi,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] meas_count,
    output logic             fail_flag,
    output logic             fail_irq
);
    import cfm_pkg::*;

    localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

    cfm_state_e       state_q, state_d;
    logic             win_tog;
    logic             win_edge;
    logic             tick;
    logic             timeout;
    logic             restart;
    logic             latch_en;
    logic             cmp_en;
    logic [CNT_W-1:0] win_cnt;
    logic [CNT_W-1:0] closed_val;
    logic             violation;

    cfm_mon_div #(.WIN_LOG2(WIN_LOG2)) u_div (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .win_tog (win_tog)
    );

    cfm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .async_in (win_tog),
        .edge_o   (win_edge)
    );

    cfm_prescaler #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_pre (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .sel_in  (div_sel),
        .restart (restart),
        .tick    (tick)
    );

    assign timeout = tick && (win_cnt == CNT_SAT) && !win_edge;
    assign restart = win_edge || timeout;

    // State register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and window actions
    always_comb begin
        state_d    = state_q;
        latch_en   = 1'b0;
        cmp_en     = 1'b0;
        closed_val = win_cnt;
        unique case (state_q)
            ST_ARM: begin
                if (win_edge) begin
                    state_d = ST_RUN;
                end else if (timeout) begin
                    state_d    = ST_RUN;
                    latch_en   = 1'b1;
                    cmp_en     = 1'b1;
                    closed_val = '0;
                end
            end
            ST_RUN: begin
                if (win_edge) begin
                    latch_en = 1'b1;
                    cmp_en   = 1'b1;
                end else if (timeout) begin
                    latch_en   = 1'b1;
                    cmp_en     = 1'b1;
                    closed_val = '0;
                end
            end
            default: state_d = ST_ARM;
        endcase
    end

    assign violation = cmp_en && ((closed_val < bound_lo) || (closed_val > bound_hi));

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (restart) begin
            win_cnt <= '0;
        end else if (tick && (win_cnt != CNT_SAT)) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_count <= '0;
            fail_flag  <= 1'b0;
            fail_irq   <= 1'b0;
        end else begin
            if (latch_en) begin
                meas_count <= closed_val;
            end
            if (violation) begin
                fail_flag <= 1'b1;
            end else if (flag_clr) begin
                fail_flag <= 1'b0;
            end
            fail_irq <= violation && !fail_flag;
        end
    end
endmodule

// File: rtl/clk_window_monitor_chk.sv
module clk_window_monitor_chk #(
    parameter int CNT_W = 8
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             flag_clr,
    input logic             fail_flag,
    input logic             fail_irq,
    input logic [CNT_W-1:0] meas_count,
    input logic [CNT_W-1:0] win_cnt,
    input logic             latch_en,
    input logic             timeout,
    input logic             restart
);
    localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

    // R8
    irq_on_rise_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fail_irq |-> (fail_flag && !$past(fail_flag)));

    // R8
    irq_single_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fail_irq |=> !fail_irq);

    // R7
    flag_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($past(fail_flag) && !$past(flag_clr)) |-> fail_flag);

    // R2
    count_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !$past(latch_en) |-> $stable(meas_count));

    // R9
    saturate_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (win_cnt == CNT_SAT && !restart) |=> (win_cnt == CNT_SAT));

    // R9
    timeout_zero_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        timeout |=> (meas_count == '0));
endmodule

bind clk_window_monitor clk_window_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .flag_clr   (flag_clr),
    .fail_flag  (fail_flag),
    .fail_irq   (fail_irq),
    .meas_count (meas_count),
    .win_cnt    (win_cnt),
    .latch_en   (latch_en),
    .timeout    (timeout),
    .restart    (restart)
);

// File: tb/clk_window_monitor_test.sv
`timescale 1ns/1ps
module clk_window_monitor_test;
    logic       ref_clk = 1'b0;
    logic       mon_clk = 1'b0;
    logic       mon_run = 1'b1;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [7:0] bound_lo = 8'd0;
    logic [7:0] bound_hi = 8'd255;
    logic       flag_clr = 1'b0;
    logic [7:0] meas_count;
    logic       fail_flag;
    logic       fail_irq;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    bit irq_prev = 1'b0;
    bit irq_wide = 1'b0;
    bit done = 1'b0;

    clk_window_monitor uut (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .mon_clk    (mon_clk),
        .div_sel    (div_sel),
        .bound_lo   (bound_lo),
        .bound_hi   (bound_hi),
        .flag_clr   (flag_clr),
        .meas_count (meas_count),
        .fail_flag  (fail_flag),
        .fail_irq   (fail_irq)
    );

    always #2.5 ref_clk = ~ref_clk;
    always begin
        #10;
        if (mon_run) mon_clk = ~mon_clk;
    end

    always @(negedge ref_clk) begin
        if (fail_irq) begin
            irq_cnt++;
            if (irq_prev) irq_wide = 1'b1;
        end
        irq_prev = fail_irq;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge ref_clk);
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        wait_cyc(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        wait_cyc(3);
        check(meas_count == 8'd0, "R1 count", meas_count, 0);
        check(fail_flag == 1'b0, "R1 flag", fail_flag, 0);
        check(fail_irq == 1'b0, "R1 irq", fail_irq, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_ratio(input logic [1:0] sel, input int exp);
        bound_lo = 8'd0;
        bound_hi = 8'd255;
        div_sel = sel;
        wait_cyc(400);
        check((meas_count >= exp - 1) && (meas_count <= exp + 1), "R2 ratio count", meas_count, exp);
    endtask

    task automatic t_in_bounds();
        div_sel = 2'd0;
        bound_lo = 8'd126;
        bound_hi = 8'd128;
        wait_cyc(400);
        check((meas_count >= 126) && (meas_count <= 128), "R2 count div1", meas_count, 127);
        check(fail_flag == 1'b0, "R6 inclusive bounds", fail_flag, 0);
    endtask

    task automatic t_low_fail();
        int base;
        base = irq_cnt;
        bound_lo = 8'd200;
        bound_hi = 8'd255;
        wait_cyc(300);
        check(fail_flag == 1'b1, "R4 below lower bound", fail_flag, 1);
        check(irq_cnt == base + 1, "R8 one pulse on set", irq_cnt, base + 1);
        wait_cyc(300);
        check(irq_cnt == base + 1, "R8 no repeat pulse", irq_cnt, base + 1);
        bound_lo = 8'd0;
        wait_cyc(300);
        check(fail_flag == 1'b1, "R7 sticky without clear", fail_flag, 1);
    endtask

    task automatic t_clear();
        bound_lo = 8'd0;
        bound_hi = 8'd255;
        pulse_clr();
        wait_cyc(300);
        check(fail_flag == 1'b0, "R7 clear strobe", fail_flag, 0);
    endtask

    task automatic t_high_fail();
        int base;
        base = irq_cnt;
        bound_lo = 8'd0;
        bound_hi = 8'd50;
        wait_cyc(300);
        check(fail_flag == 1'b1, "R5 above upper bound", fail_flag, 1);
        check(irq_cnt == base + 1, "R8 pulse after clear", irq_cnt, base + 1);
        bound_hi = 8'd255;
        pulse_clr();
    endtask

    task automatic t_stopped();
        bound_lo = 8'd0;
        bound_hi = 8'd255;
        pulse_clr();
        wait_cyc(10);
        bound_lo = 8'd1;
        mon_run = 1'b0;
        wait_cyc(700);
        check(meas_count == 8'd0, "R9 stopped clock count", meas_count, 0);
        check(fail_flag == 1'b1, "R9 stopped clock flag", fail_flag, 1);
        mon_run = 1'b1;
        bound_lo = 8'd0;
    endtask

    task automatic t_first_discard();
        bound_lo = 8'd200;
        bound_hi = 8'd255;
        div_sel = 2'd0;
        do_reset();
        wait_cyc(200);
        check(fail_flag == 1'b0, "R10 first window dropped", fail_flag, 0);
        check(meas_count == 8'd0, "R10 no latch on first edge", meas_count, 0);
        wait_cyc(100);
        check(fail_flag == 1'b1, "R10 second window checked", fail_flag, 1);
    endtask

    task automatic t_sel_boundary();
        bound_lo = 8'd0;
        bound_hi = 8'd255;
        div_sel = 2'd0;
        do_reset();
        wait_cyc(200);
        div_sel = 2'd3;
        wait_cyc(90);
        check((meas_count >= 126) && (meas_count <= 128), "R3 old ratio kept", meas_count, 127);
        wait_cyc(130);
        check((meas_count >= 14) && (meas_count <= 16), "R3 new ratio next window", meas_count, 15);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_in_bounds();
        t_ratio(2'd1, 63);
        t_ratio(2'd2, 31);
        t_ratio(2'd3, 15);
        div_sel = 2'd0;
        wait_cyc(300);
        t_low_fail();
        t_clear();
        t_high_fail();
        t_stopped();
        t_first_discard();
        t_sel_boundary();
        check(irq_wide == 1'b0, "R8 pulse width one", irq_wide, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule